// File: doc/BRIEF.md
# Opportunistic Per-Bank Refresh Scheduler

This block sits inside a memory controller and decides when a per-bank refresh is issued and which bank it goes to. A free-running interval tick adds one owed refresh to every bank. The scheduler holds these refreshes back while banks have demand traffic, and spends them on banks that are idle. When the controller is draining a batch of writes, queued banks also become targets, because writes can absorb the refresh delay. When a bank's debt reaches the postponement limit, that bank is forced to the front of the line.

The scheduler offers one refresh at a time to the command arbiter as a request with a bank index. It keeps that offer until the arbiter grants it. A granted bank is marked as refreshing for a programmable number of cycles. During that time it cannot be chosen again. The other banks stay free to serve accesses. Ties between equally eligible banks are broken by a rotating pointer. The pointer starts one past the most recently granted bank, so no bank starves.

The control is a two-state machine. In state ST_IDLE the scheduler looks for a candidate. The transition *offer* goes from ST_IDLE to ST_OFFER when a candidate exists, and latches its index. In ST_OFFER the request is driven. The transition *grant* returns to ST_IDLE when the arbiter accepts. With no grant the machine stays in ST_OFFER (*hold*). With no candidate it stays in ST_IDLE (*wait*).

Top module: `refresh_sched`

## Requirements
- R1: After reset `ref_req` is 0, `refreshing` is all zero, every bank owes nothing, and the rotation pointer is at bank 0.
- R2: Each bank's debt rises by one on every cycle with `ref_tick` high and falls by one on each grant to that bank. A tick and a grant to the same bank in one cycle leave the debt unchanged. The debt saturates at DEBT_MAX (8), so a bank never receives more than 8 grants without a further tick.
- R3: A bank is eligible only if its debt is above zero, its `bank_busy` bit is 0, and its `refreshing` bit is 0. An offered bank is never one that is refreshing.
- R4: An eligible bank whose debt equals DEBT_MAX is forced. When any forced bank exists, only forced banks are candidates, regardless of their queued request counts.
- R5: With no forced bank, an eligible bank whose 4-bit pending count (bits 4*b+3..4*b of `bank_pend` for bank b) is zero is chosen ahead of banks with queued requests.
- R6: Outside drain mode, an eligible bank with a nonzero pending count and debt below DEBT_MAX is not offered; its refresh is postponed.
- R7: While `drain_mode` is 1, eligible banks with queued requests are candidates too, after forced and idle banks.
- R8: Among candidates of the same class, the first one found scanning upward from the rotation pointer, wrapping after bank 7, is chosen. Each grant moves the pointer to the granted bank plus one, modulo 8.
- R9: `ref_req` rises in the cycle after the scheduler, in ST_IDLE, sees a candidate. `ref_bank` stays constant while `ref_req` is high without a grant. `ref_req` is low in the cycle after a grant.
- R10: After a grant to bank b, `refreshing[b]` is high for exactly `trfc_cycles` cycles (1 or more), starting in the cycle after the grant. The other bits are unaffected.
- R11: `ref_gnt` while `ref_req` is low has no effect: no debt changes and no bank starts refreshing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Refresh interval tick, adds one owed refresh to every bank |
| bank_pend | input | NB*QW (32) | Pending demand request count per bank, 4 bits each, bank 0 in the low bits |
| bank_busy | input | NB (8) | Bank currently unable to take a refresh command |
| drain_mode | input | 1 | Controller is draining a write batch |
| trfc_cycles | input | TW (8) | Refresh latency in cycles, loaded on each grant |
| ref_req | output | 1 | Refresh offer to the command arbiter |
| ref_bank | output | BW (3) | Bank index of the offered refresh |
| ref_gnt | input | 1 | Arbiter accepts the offered refresh |
| refreshing | output | NB (8) | Per-bank refresh-in-progress flags |

## Verification
The bench builds debt to the limit while every bank is busy, then drains it. A counter that wraps or keeps climbing past 8 would hand out too few or too many grants per bank. Directed cases check each priority class on its own. An idle bank must win over banks with a queue. Queued banks must stay untouched until drain mode begins, and must then be served in pointer order. A design that ignored queue depth, or the drain flag, would offer the wrong bank or offer too early. When all debts reach the limit together, the forced class must fire even though every queue is full and drain is off. The forced bank must then give way to the next bank once its debt drops. A random phase with stray grants and varied refresh latencies is compared cycle by cycle against a bench model. It targets off-by-one refresh windows and offers to banks that are still refreshing.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } rs_state_e;
endpackage

// File: rtl/refresh_debt.sv
// Saturating owed-refresh counter for one bank.
module refresh_debt #(
    parameter int DEBT_MAX = 8,
    parameter int DW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          dec,
    output logic [DW-1:0] debt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
        end else if (tick && !dec) begin
            if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
        end else if (dec && !tick) begin
            debt <= debt - 1'b1;
        end
    end
endmodule

// File: rtl/refresh_timer.sv
// Per-bank refresh latency countdown.
module refresh_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] cycles,
    output logic          active
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (load)     cnt <= cycles;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/refresh_picker.sv
// Class-ordered candidate selection with rotating tie-break.
module refresh_picker #(
    parameter int NB       = 8,
    parameter int QW       = 4,
    parameter int DW       = 4,
    parameter int DEBT_MAX = 8,
    parameter int BW       = 3
) (
    input  logic [NB*DW-1:0] debt_flat,
    input  logic [NB*QW-1:0] pend_flat,
    input  logic [NB-1:0]    busy,
    input  logic [NB-1:0]    active,
    input  logic             drain,
    input  logic [BW-1:0]    ptr,
    output logic             found,
    output logic [BW-1:0]    sel
);
    logic [NB-1:0] forced_m, idle_m, queued_m, pick_m;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            logic [DW-1:0] d;
            logic          elig;
            d           = debt_flat[b*DW +: DW];
            elig        = (d != '0) && !busy[b] && !active[b];
            forced_m[b] = elig && (d == DW'(DEBT_MAX));
            idle_m[b]   = elig && (pend_flat[b*QW +: QW] == '0);
            queued_m[b] = elig && drain;
        end
        if (forced_m != '0)    pick_m = forced_m;
        else if (idle_m != '0) pick_m = idle_m;
        else                   pick_m = queued_m;

        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NB; i++) begin
            int idx;
            idx = (int'(ptr) + i) % NB;
            if (!found && pick_m[idx]) begin
                found = 1'b1;
                sel   = BW'(idx);
            end
        end
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int NB       = 8,
    parameter int QW       = 4,
    parameter int DEBT_MAX = 8,
    parameter int TW       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic [NB*QW-1:0]   bank_pend,
    input  logic [NB-1:0]      bank_busy,
    input  logic               drain_mode,
    input  logic [TW-1:0]      trfc_cycles,
    output logic               ref_req,
    output logic [$clog2(NB)-1:0] ref_bank,
    input  logic               ref_gnt,
    output logic [NB-1:0]      refreshing
);
    import refresh_pkg::*;

    localparam int BW = $clog2(NB);
    localparam int DW = $clog2(DEBT_MAX + 1);

    rs_state_e       state, state_n;
    logic [BW-1:0]   offer_bank;
    logic [BW-1:0]   rot_ptr;
    logic            cand_found;
    logic [BW-1:0]   cand_bank;
    logic            grant_fire;
    logic [NB-1:0]   dec_vec;
    logic [NB*DW-1:0] debt_flat;

    assign grant_fire = ref_req && ref_gnt;

    generate
        for (genvar g = 0; g < NB; g++) begin : g_bank
            assign dec_vec[g] = grant_fire && (offer_bank == BW'(g));

            refresh_debt #(.DEBT_MAX(DEBT_MAX), .DW(DW)) u_debt (
                .clk  (clk),
                .rst_n(rst_n),
                .tick (ref_tick),
                .dec  (dec_vec[g]),
                .debt (debt_flat[g*DW +: DW])
            );

            refresh_timer #(.TW(TW)) u_timer (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (dec_vec[g]),
                .cycles(trfc_cycles),
                .active(refreshing[g])
            );
        end
    endgenerate

    refresh_picker #(
        .NB(NB), .QW(QW), .DW(DW), .DEBT_MAX(DEBT_MAX), .BW(BW)
    ) u_picker (
        .debt_flat(debt_flat),
        .pend_flat(bank_pend),
        .busy     (bank_busy),
        .active   (refreshing),
        .drain    (drain_mode),
        .ptr      (rot_ptr),
        .found    (cand_found),
        .sel      (cand_bank)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions: wait / offer / hold / grant
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (cand_found) state_n = ST_OFFER;
            ST_OFFER: if (ref_gnt)    state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // latched target and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_bank <= '0;
            rot_ptr    <= '0;
        end else begin
            if (state == ST_IDLE && cand_found) offer_bank <= cand_bank;
            if (grant_fire)
                rot_ptr <= (offer_bank == BW'(NB - 1)) ? '0 : offer_bank + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ref_req  = (state == ST_OFFER);
        ref_bank = offer_bank;
    end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int NB       = 8,
    parameter int DW       = 4,
    parameter int DEBT_MAX = 8,
    parameter int BW       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_req,
    input logic             ref_gnt,
    input logic [BW-1:0]    ref_bank,
    input logic [NB-1:0]    refreshing,
    input logic [NB*DW-1:0] debt_flat
);
    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_gnt |=> ref_req && $stable(ref_bank));

    // R9
    offer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> !ref_req);

    // R3
    target_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !refreshing[ref_bank]);

    // R10
    refresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> refreshing[$past(ref_bank)]);

    // R11
    stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |=> (refreshing & ~$past(refreshing)) == '0);

    generate
        for (genvar g = 0; g < NB; g++) begin : g_cap
            // R2
            debt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                debt_flat[g*DW +: DW] <= DW'(DEBT_MAX));
        end
    endgenerate
endmodule

bind refresh_sched refresh_sched_chk #(
    .NB(NB), .DW(DW), .DEBT_MAX(DEBT_MAX), .BW(BW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_req   (ref_req),
    .ref_gnt   (ref_gnt),
    .ref_bank  (ref_bank),
    .refreshing(refreshing),
    .debt_flat (debt_flat)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int NB = 8;
    localparam int MAXD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [31:0] bank_pend = '0;
    logic [7:0]  bank_busy = '0;
    logic        drain_mode = 1'b0;
    logic [7:0]  trfc_cycles = 8'd1;
    logic        ref_req;
    logic [2:0]  ref_bank;
    logic        ref_gnt = 1'b0;
    logic [7:0]  refreshing;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model state
    int m_debt[NB];
    int m_rc[NB];
    bit m_off;
    int m_bank;
    int m_ptr;

    always #2.5 clk = ~clk;

    refresh_sched u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bank_pend(bank_pend),
        .bank_busy(bank_busy), .drain_mode(drain_mode), .trfc_cycles(trfc_cycles),
        .ref_req(ref_req), .ref_bank(ref_bank), .ref_gnt(ref_gnt),
        .refreshing(refreshing)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int b = 0; b < NB; b++) begin m_debt[b] = 0; m_rc[b] = 0; end
        m_off = 0; m_bank = 0; m_ptr = 0;
    endfunction

    // candidate choice from R3..R8
    function automatic int exp_pick(logic [31:0] pd, logic [7:0] bs, bit dr);
        bit [7:0] f, i, q, p;
        for (int b = 0; b < NB; b++) begin
            bit el;
            el   = (m_debt[b] > 0) && !bs[b] && (m_rc[b] == 0);
            f[b] = el && (m_debt[b] == MAXD);
            i[b] = el && (pd[b*4 +: 4] == 4'd0);
            q[b] = el && dr;
        end
        p = (f != 0) ? f : ((i != 0) ? i : q);
        for (int k = 0; k < NB; k++) begin
            int idx;
            idx = (m_ptr + k) % NB;
            if (p[idx]) return idx;
        end
        return -1;
    endfunction

    function automatic void model_adv(bit tk, logic [31:0] pd, logic [7:0] bs,
                                      bit dr, bit gn, int tr);
        int sel;
        bit fire;
        sel  = exp_pick(pd, bs, dr);
        fire = m_off && gn;
        for (int b = 0; b < NB; b++) begin
            bit dec;
            dec = fire && (b == m_bank);
            if (tk && !dec) begin
                if (m_debt[b] < MAXD) m_debt[b]++;
            end else if (dec && !tk) m_debt[b]--;
            if (dec) m_rc[b] = tr;
            else if (m_rc[b] > 0) m_rc[b]--;
        end
        if (!m_off) begin
            if (sel >= 0) begin m_off = 1; m_bank = sel; end
        end else if (gn) begin
            m_off = 0;
            m_ptr = (m_bank + 1) % NB;
        end
    endfunction

    function automatic logic [7:0] model_mask();
        logic [7:0] m;
        for (int b = 0; b < NB; b++) m[b] = (m_rc[b] > 0);
        return m;
    endfunction

    // called at a negedge; applies inputs for one cycle and checks at next negedge
    task automatic step(bit tk, logic [31:0] pd, logic [7:0] bs, bit dr, bit gn, int tr);
        ref_tick = tk; bank_pend = pd; bank_busy = bs;
        drain_mode = dr; ref_gnt = gn; trfc_cycles = 8'(tr);
        model_adv(tk, pd, bs, dr, gn, tr);
        @(posedge clk);
        @(negedge clk);
        chk(ref_req == m_off, "R9 ref_req", int'(ref_req), int'(m_off));
        if (m_off) chk(ref_bank == 3'(m_bank), "R8 ref_bank", int'(ref_bank), m_bank);
        chk(refreshing == model_mask(), "R10 refreshing", int'(refreshing), int'(model_mask()));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_tick = 0; bank_pend = '0; bank_busy = '0; drain_mode = 0; ref_gnt = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
        chk(refreshing == 8'h00, "R1 refreshing", int'(refreshing), 0);
    endtask

    initial begin
        int seed;
        logic [31:0] busy_pend;
        int gcount[NB];
        seed = $urandom(32'h2f1d);
        busy_pend = 32'h3333_3333;
        do_reset();

        // R5: only bank 5 idle
        step(1, 32'h3303_3333, 8'h00, 0, 0, 4);
        step(0, 32'h3303_3333, 8'h00, 0, 0, 4);
        chk(ref_req && ref_bank == 3'd5, "R5 idle bank first", int'(ref_bank), 5);
        step(0, 32'h3303_3333, 8'h00, 0, 1, 4);
        // R10: 4-cycle window
        chk(refreshing == 8'h20, "R10 window start", int'(refreshing), 32);
        step(0, busy_pend, 8'h00, 0, 0, 4);
        step(0, busy_pend, 8'h00, 0, 0, 4);
        step(0, busy_pend, 8'h00, 0, 0, 4);
        chk(refreshing == 8'h20, "R10 window last", int'(refreshing), 32);
        step(0, busy_pend, 8'h00, 0, 0, 4);
        chk(refreshing == 8'h00, "R10 window end", int'(refreshing), 0);
        // R6: queued banks postponed
        chk(ref_req == 1'b0, "R6 postponed", int'(ref_req), 0);

        // R7 / R8: drain mode serves queued banks in pointer order from 6
        for (int k = 0; k < 7; k++) begin
            int e;
            e = (6 + k + (k >= 7 ? 1 : 0)) % NB;
            if (e == 5) e = 6;
            e = (k < 2) ? 6 + k : k - 2;
            step(0, busy_pend, 8'h00, 1, 0, 2);
            chk(ref_req && ref_bank == 3'(e), "R7 drain order", int'(ref_bank), e);
            step(0, busy_pend, 8'h00, 1, 1, 2);
        end

        // R4: all debts reach the limit with full queues and no drain
        for (int k = 0; k < 7; k++) step(1, busy_pend, 8'h00, 0, 0, 2);
        step(0, busy_pend, 8'h00, 0, 0, 2);
        chk(ref_req == 1'b0, "R6 below limit", int'(ref_req), 0);
        step(1, busy_pend, 8'h00, 0, 0, 2);
        step(0, busy_pend, 8'h00, 0, 0, 2);
        chk(ref_req && ref_bank == 3'd5, "R4 forced bank", int'(ref_bank), 5);
        step(0, busy_pend, 8'h00, 0, 1, 2);
        step(0, busy_pend, 8'h00, 0, 0, 2);
        chk(ref_req && ref_bank == 3'd6, "R4 next forced", int'(ref_bank), 6);
        step(0, busy_pend, 8'h00, 0, 1, 2);

        // R2: saturation, 12 ticks while all busy, then drain everything
        do_reset();
        for (int k = 0; k < 12; k++) step(1, busy_pend, 8'hFF, 0, 0, 1);
        for (int b = 0; b < NB; b++) gcount[b] = 0;
        for (int k = 0; k < 200; k++) begin
            if (ref_req) gcount[ref_bank]++;
            step(0, busy_pend, 8'h00, 1, 1, 1);
        end
        for (int b = 0; b < NB; b++)
            chk(gcount[b] == MAXD, "R2 grants per bank", gcount[b], MAXD);

        // R11: stray grants
        step(0, 32'h0, 8'h00, 0, 1, 3);
        step(0, 32'h0, 8'h00, 0, 1, 3);
        chk(refreshing == 8'h00 && !ref_req, "R11 stray grant", int'(refreshing), 0);

        // random phase against the model
        begin
            bit dr;
            dr = 0;
            for (int k = 0; k < 4000; k++) begin
                logic [31:0] pd;
                logic [7:0]  bs;
                for (int b = 0; b < NB; b++) begin
                    pd[b*4 +: 4] = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom % 16);
                    bs[b] = ($urandom % 4 == 0);
                end
                if ($urandom % 50 == 0) dr = !dr;
                step(($urandom % 12 == 0), pd, bs, dr, ($urandom % 2 == 0),
                     1 + int'($urandom % 12));
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule